// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block counts events on an external pin rather than ticks of the system clock. Software picks which pin transitions count: rising, falling or both. Software can also stop counting altogether. The pin is brought into the system clock domain by a two-stage synchronizer. An edge is then found by comparing the synchronized level with its value one cycle earlier. Each recognized edge moves a 16-bit register by one, up or down.

The counting direction comes from a software bit. When an enable is set, an external direction pin inverts that bit. A run input gates all counting.

When the register wraps past its top or bottom value, three things happen on the same clock edge: an output toggle latch flips, an interrupt request pulses for one cycle, and a matching one-cycle pulse goes out to neighbouring timers. Software can load the register and write the toggle latch directly. A load in the same cycle as a count event wins over the event.

Top module: `evt_counter`

## Requirements
- R1: After reset, count_o is 0x0000, and toggle_o, irq_o and aux_o are 0.
- R2: With edge_sel_i = 3'b001, each 0-to-1 change on cnt_pin_i moves the count by one. A 1-to-0 change does not move it.
- R3: With edge_sel_i = 3'b010, each 1-to-0 change on cnt_pin_i moves the count by one. A 0-to-1 change does not move it.
- R4: With edge_sel_i = 3'b011, every change of cnt_pin_i moves the count by one.
- R5: With edge_sel_i = 3'b000, or any code with bit 2 set (3'b1xx), edges on cnt_pin_i leave the count unchanged.
- R6: While run_i is 0, edges on cnt_pin_i leave the count unchanged.
- R7: The count goes down when (sw_down_i XOR (ext_dir_en_i AND dir_pin_i)) is 1, and up otherwise.
- R8: Counting up from 0xFFFF gives 0x0000 and is an overflow. Counting down from 0x0000 gives 0xFFFF and is an underflow.
- R9: On each overflow or underflow, toggle_o inverts, and irq_o and aux_o are both 1 for exactly the cycle after the wrapping edge.
- R10: A cycle with load_en_i = 1 sets count_o to load_val_i on the next edge. Any count event in that same cycle is dropped and produces no pulse.
- R11: A cycle with tgl_wr_en_i = 1 sets toggle_o to tgl_wr_val_i on the next edge. This write wins over a wrap-driven flip in the same cycle.
- R12: A pin change that is set up before clock edge k shows on count_o after clock edge k+2. The direction pin passes through the same two-stage synchronizer.
- R13: Pin levels held for at least 8 clock cycles are each counted, with no event lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_pin_i | input | 1 | Asynchronous count event pin |
| dir_pin_i | input | 1 | Asynchronous external direction pin |
| run_i | input | 1 | Counting enable |
| edge_sel_i | input | 3 | Counting edge select |
| sw_down_i | input | 1 | Software direction, 1 = down |
| ext_dir_en_i | input | 1 | Lets dir_pin_i invert the direction |
| load_en_i | input | 1 | Load strobe for the count register |
| load_val_i | input | 16 | Value to load |
| tgl_wr_en_i | input | 1 | Write strobe for the toggle latch |
| tgl_wr_val_i | input | 1 | Value written to the toggle latch |
| count_o | output | 16 | Current count |
| toggle_o | output | 1 | Toggle latch output |
| irq_o | output | 1 | One-cycle interrupt request on wrap |
| aux_o | output | 1 | One-cycle pulse to other timers on wrap |

## Verification
The count pin is driven in slow square waves under each edge code. This separates rising-only, falling-only and both-edge counting from the disabled and reserved codes. The run gate is exercised the same way.

Each combination of direction bit, external-direction enable and direction pin level is tried, which shows whether the XOR inversion is applied and whether the enable masks it. Loads just below 0xFFFF and just above 0x0000 force overflow and underflow, so the bench can watch the pulses and the latch flips.

A pin that toggles every cycle, combined with loads and latch writes, puts count events and software writes in the same cycle. That pattern shows which one wins.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

    typedef enum logic [2:0] {
        EDGE_OFF  = 3'b000,
        EDGE_RISE = 3'b001,
        EDGE_FALL = 3'b010,
        EDGE_ANY  = 3'b011
    } edge_mode_e;

    function automatic logic mode_reserved(input logic [2:0] mode);
        return mode[2];
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/evt_edge_sel.sv
module evt_edge_sel
    import evt_counter_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       level_i,
    input  logic [2:0] mode_i,
    output logic       hit_o
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = level_i;
        rise   = level_i & ~prev_q;
        fall   = ~level_i & prev_q;
        hit_o  = 1'b0;
        if (!mode_reserved(mode_i)) begin
            unique case (edge_mode_e'(mode_i))
                EDGE_RISE: hit_o = rise;
                EDGE_FALL: hit_o = fall;
                EDGE_ANY:  hit_o = rise | fall;
                default:   hit_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/evt_core.sv
module evt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             down_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tgl_wr_en_i,
    input  logic             tgl_wr_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             toggle_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             toggle;
        logic             wrap;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        at_edge;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        at_edge   = down_i ? (st_q.count == CNT_MIN) : (st_q.count == CNT_MAX);
        if (load_en_i) begin
            st_d.count = load_val_i;
        end else if (step_i) begin
            st_d.count = down_i ? st_q.count - 1'b1 : st_q.count + 1'b1;
            if (at_edge) begin
                st_d.wrap   = 1'b1;
                st_d.toggle = ~st_q.toggle;
            end
        end
        if (tgl_wr_en_i) st_d.toggle = tgl_wr_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o  = st_q.count;
    assign toggle_o = st_q.toggle;
    assign wrap_o   = st_q.wrap;
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_pin_i,
    input  logic             dir_pin_i,
    input  logic             run_i,
    input  logic [2:0]       edge_sel_i,
    input  logic             sw_down_i,
    input  logic             ext_dir_en_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tgl_wr_en_i,
    input  logic             tgl_wr_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             toggle_o,
    output logic             irq_o,
    output logic             aux_o
);
    logic [1:0] pins_sync;
    logic       edge_hit;
    logic       step;
    logic       down;
    logic       wrap;

    evt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({dir_pin_i, cnt_pin_i}),
        .sync_o (pins_sync)
    );

    evt_edge_sel u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(pins_sync[0]),
        .mode_i (edge_sel_i),
        .hit_o  (edge_hit)
    );

    always_comb begin
        step = run_i & edge_hit;
        down = sw_down_i ^ (ext_dir_en_i & pins_sync[1]);
    end

    evt_core #(.CNT_W(CNT_W)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_i      (step),
        .down_i      (down),
        .load_en_i   (load_en_i),
        .load_val_i  (load_val_i),
        .tgl_wr_en_i (tgl_wr_en_i),
        .tgl_wr_val_i(tgl_wr_val_i),
        .count_o     (count_o),
        .toggle_o    (toggle_o),
        .wrap_o      (wrap)
    );

    assign irq_o = wrap;
    assign aux_o = wrap;
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic [2:0]       edge_sel_i,
    input logic             load_en_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic             tgl_wr_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             toggle_o,
    input logic             irq_o,
    input logic             aux_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_en_i |=> count_o == $past(load_val_i)); // R10

    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_en_i) |=> $stable(count_o)); // R6

    AST_RESERVED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_sel_i[2] && !load_en_i) |=> $stable(count_o)); // R5

    AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + ONE
                        || count_o == $past(count_o) - ONE)); // R7

    AST_WRAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (count_o == '0 || count_o == '1)); // R8

    AST_WRAP_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tgl_wr_en_i && !load_en_i) |=> (irq_o == (toggle_o != $past(toggle_o)))); // R9

    AST_PULSES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == aux_o); // R9
endmodule

bind evt_counter evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .edge_sel_i (edge_sel_i),
    .load_en_i  (load_en_i),
    .load_val_i (load_val_i),
    .tgl_wr_en_i(tgl_wr_en_i),
    .count_o    (count_o),
    .toggle_o   (toggle_o),
    .irq_o      (irq_o),
    .aux_o      (aux_o)
);

// File: tb/evt_counter_test.sv
`timescale 1ns/1ps
module evt_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_pin = 1'b0, dir_pin = 1'b0, run = 1'b0;
    logic [2:0]  esel = 3'b000;
    logic        sw_down = 1'b0, xdir_en = 1'b0;
    logic        ld_en = 1'b0, tw_en = 1'b0, tw_val = 1'b0;
    logic [15:0] ld_val = 16'h0;
    logic [15:0] count;
    logic        toggle, irq, aux;

    int n_chk = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    evt_counter uut (
        .clk_i(clk), .rst_ni(rst_n), .cnt_pin_i(cnt_pin), .dir_pin_i(dir_pin),
        .run_i(run), .edge_sel_i(esel), .sw_down_i(sw_down), .ext_dir_en_i(xdir_en),
        .load_en_i(ld_en), .load_val_i(ld_val), .tgl_wr_en_i(tw_en),
        .tgl_wr_val_i(tw_val), .count_o(count), .toggle_o(toggle),
        .irq_o(irq), .aux_o(aux)
    );

    // Behavioural reference: pin histories sampled at each rising clock edge
    int          cnt_hist[$];
    int          dir_hist[$];
    int          m_cnt = 0;
    bit          m_tog = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_hist = '{0, 0, 0};
            dir_hist = '{0, 0, 0};
            m_cnt = 0; m_tog = 0; m_irq = 0;
        end else begin
            int  lvl, old, dlv;
            bit  hit, dn;
            lvl = cnt_hist[1];   // pin seen two edges back (R12)
            old = cnt_hist[0];
            dlv = dir_hist[1];
            case (esel)
                3'b001: hit = (lvl == 1 && old == 0);
                3'b010: hit = (lvl == 0 && old == 1);
                3'b011: hit = (lvl != old);
                default: hit = 0;
            endcase
            hit = hit && run;
            dn = sw_down ^ (xdir_en && dlv == 1);
            m_irq = 0;
            if (ld_en) m_cnt = ld_val;
            else if (hit) begin
                if (dn) begin
                    if (m_cnt == 0) begin m_cnt = 65535; m_irq = 1; m_tog = !m_tog; end
                    else m_cnt = m_cnt - 1;
                end else begin
                    if (m_cnt == 65535) begin m_cnt = 0; m_irq = 1; m_tog = !m_tog; end
                    else m_cnt = m_cnt + 1;
                end
            end
            if (tw_en) m_tog = tw_val;
            cnt_hist.push_back(int'(cnt_pin)); void'(cnt_hist.pop_front());
            dir_hist.push_back(int'(dir_pin)); void'(dir_hist.pop_front());
        end
    end

    always @(negedge clk) begin
        cycles++;
        n_chk++;
        if (count !== 16'(m_cnt) || toggle !== m_tog || irq !== m_irq || aux !== m_irq) begin
            n_fail++;
            $display("FAIL %s: count=%h tog=%b irq=%b aux=%b expected count=%h tog=%b irq=%b",
                     cur_req, count, toggle, irq, aux, 16'(m_cnt), m_tog, m_irq);
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1'b1; wait_cyc(hold);
            cnt_pin = 1'b0; wait_cyc(hold);
        end
    endtask

    task automatic check_val(input string req, input logic [15:0] exp);
        n_chk++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%h expected %h", req, count, exp);
        end
    endtask

    task automatic load(input logic [15:0] v);
        ld_val = v; ld_en = 1'b1; wait_cyc(1); ld_en = 1'b0; wait_cyc(1);
    endtask

    initial begin
        wait_cyc(3);
        cur_req = "R1";
        check_val("R1", 16'h0000);
        rst_n = 1'b1;
        wait_cyc(2);
        run = 1'b1;

        cur_req = "R2"; esel = 3'b001;      // R13: holds of 8 cycles
        pulses(5, 8); wait_cyc(4);
        check_val("R2", 16'd5);

        cur_req = "R3"; esel = 3'b010;
        pulses(4, 8); wait_cyc(4);
        check_val("R3", 16'd9);

        cur_req = "R4"; esel = 3'b011;
        pulses(3, 8); wait_cyc(4);
        check_val("R4", 16'd15);

        cur_req = "R13"; pulses(6, 8); wait_cyc(4);
        check_val("R13", 16'd27);

        cur_req = "R5";
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 4) begin
                esel = 3'(c); pulses(2, 8); wait_cyc(4);
                check_val("R5", 16'd27);
            end
        end

        cur_req = "R6"; esel = 3'b011; run = 1'b0;
        pulses(3, 8); wait_cyc(4);
        check_val("R6", 16'd27);
        run = 1'b1;

        cur_req = "R7";
        for (int k = 0; k < 8; k++) begin
            sw_down = k[0]; xdir_en = k[1]; dir_pin = k[2];
            wait_cyc(4);
            pulses(2, 8); wait_cyc(4);
        end
        sw_down = 1'b0; xdir_en = 1'b0; dir_pin = 1'b0;

        cur_req = "R8"; load(16'hFFFE);
        pulses(2, 8); wait_cyc(4);
        check_val("R8", 16'h0002);
        cur_req = "R9"; sw_down = 1'b1; load(16'h0001);
        pulses(2, 8); wait_cyc(4);
        check_val("R9", 16'hFFFD);
        sw_down = 1'b0;

        cur_req = "R10"; load(16'hFFFF);
        for (int i = 0; i < 24; i++) begin
            cnt_pin = ~cnt_pin;
            ld_en = (i % 3 == 0); ld_val = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
            sw_down = (i % 5 == 0);
            wait_cyc(1);
        end
        ld_en = 1'b0; sw_down = 1'b0;

        cur_req = "R11"; load(16'hFFFF);
        for (int i = 0; i < 24; i++) begin
            cnt_pin = ~cnt_pin;
            tw_en = (i % 2 == 0); tw_val = (i % 4 == 0);
            if (i % 6 == 0) begin ld_en = 1'b1; ld_val = 16'hFFFF; end
            else ld_en = 1'b0;
            wait_cyc(1);
        end
        tw_en = 1'b0; ld_en = 1'b0;

        cur_req = "R12"; cnt_pin = 1'b0; esel = 3'b001; wait_cyc(6);
        load(16'h0100);
        cnt_pin = 1'b1; wait_cyc(2);
        check_val("R12", 16'h0100);
        wait_cyc(1);
        check_val("R12", 16'h0101);
        wait_cyc(8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule